// File: doc/BRIEF.md
# Programmable Interval and Event Counter with Toggle Output

An 8-bit counting peripheral that either times intervals from one of four prescaled versions of the system clock or counts rising edges of an asynchronous external event line. The running count is compared with a host-written modulo value. When a count pulse arrives while the count equals that value, the count wraps to zero, a one-cycle interrupt request is raised and an output flip-flop flips. One piece of logic therefore gives interval timing, a square wave of chosen frequency, and division of an external signal by a programmable factor.

The host writes a whole-byte mode word holding the source select, a run enable and a self-clearing start command. It can also raise the start command alone through a separate strobe that leaves the rest of the word as it is. A separate enable flag decides whether the flip-flop reaches the output pin. The flip-flop is also exported without that gate, for use as a serial shift clock. The count is visible at all times on a read port.

Top module: `evt_timer`

## Requirements
- R1: A synchronous reset clears the mode word, the output-enable flag, the count, the output flip-flop, the pin and the interrupt request to 0.
- R2: A mode write stores all 8 bits of `mode_wdata`, and `mode_q` returns them. The layout is: bit 2 = run enable, bit 3 = start command, bits 6:4 = source code, bits 7, 1 and 0 are stored only.
- R3: A start command is either a mode write with bit 3 = 1 or a `start_set` pulse. It clears the count, the output flip-flop and the prescaler at that clock edge. `start_set` leaves the other mode bits unchanged. Bit 3 reads 1 for exactly one cycle after the command and then reads 0.
- R4: With run = 1, source codes 1, 2, 3 and 4 give one count pulse every 4, 16, 64 and 256 clock cycles. The first pulse lands that many edges after the start edge.
- R5: A count pulse that arrives while the count equals the modulo value returns the count to 0, inverts the output flip-flop and sets `irq` high for exactly the following cycle. The output period is therefore (modulo + 1) count pulses per half-wave.
- R6: Source code 5 counts rising edges of `ext_evt` after a two-stage synchronizer. The output therefore divides the input frequency by 2 × (modulo + 1).
- R7: With run = 0, or with source code 0, 6 or 7, the count holds its value. A mode write with bit 3 = 0 does not clear the count.
- R8: `tout_pin` equals the output flip-flop when the enable flag is 1 and is 0 otherwise. `shift_clk` always follows the flip-flop.
- R9: `count_q` shows the live count on every cycle, and reading it does not disturb counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the whole mode byte |
| mode_wdata | input | 8 | Mode byte to store |
| start_set | input | 1 | Raises the start command alone |
| oe_we | input | 1 | Write strobe for the output-enable flag |
| oe_wdata | input | 1 | New output-enable value |
| modulo_we | input | 1 | Write strobe for the modulo value |
| modulo_wdata | input | 8 | New modulo value |
| ext_evt | input | 1 | Asynchronous external event line |
| mode_q | output | 8 | Current mode byte |
| count_q | output | 8 | Live count |
| irq | output | 1 | One-cycle match interrupt request |
| tout_pin | output | 1 | Gated output flip-flop |
| shift_clk | output | 1 | Ungated output flip-flop |

## Verification
A wrong count or a lost wrap shows on `count_q` on the very next count pulse. It also shifts the phase of `tout_pin` and `irq` by at least one count period, so the bench samples at exact edge offsets and compares against closed-form values from elapsed pulses. A prescaler that is not cleared at start moves the first pulse, and a start bit that stays high reappears in `mode_q` one cycle later. Both are checked on the cycle itself, and a missed flip-flop clear shows at once on `shift_clk`.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int DATA_W    = 8;
    localparam int TAP_COUNT = 4;
    localparam int TAP_STEP  = 2;
    localparam int PRE_W     = TAP_COUNT * TAP_STEP;
    localparam int SRC_W     = 3;
    localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(TAP_COUNT + 1);

    typedef struct packed {
        logic             spare_hi;
        logic [SRC_W-1:0] src;
        logic             start;
        logic             run;
        logic [1:0]       spare_lo;
    } mode_t;

    typedef struct packed {
        logic              tout;
        logic              irq;
        logic [DATA_W-1:0] count;
    } core_state_t;
endpackage

// File: rtl/evt_tmr_prescale.sv
module evt_tmr_prescale #(
    parameter int TAPS = 4,
    parameter int STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    output logic [TAPS-1:0] tap_tick
);
    localparam int W = TAPS * STEP;
    logic [W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) pre <= '0;
        else            pre <= pre + 1'b1;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign tap_tick[k] = &pre[(k+1)*STEP-1:0];
    end
endmodule

// File: rtl/evt_tmr_sync.sv
module evt_tmr_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
        end else begin
            s1 <= async_in; s2 <= s1; s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;

    // R6
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/evt_tmr_core.sv
module evt_tmr_core
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic [DATA_W-1:0] modulo,
    output core_state_t       st
);
    core_state_t st_r;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_r <= '0;
        end else begin
            st_r.irq <= 1'b0;
            if (tick) begin
                if (st_r.count == modulo) begin
                    st_r.count <= '0;
                    st_r.tout  <= ~st_r.tout;
                    st_r.irq   <= 1'b1;
                end else begin
                    st_r.count <= st_r.count + 1'b1;
                end
            end
        end
    end

    assign st = st_r;

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(clr) |-> (st_r.count == '0 && !st_r.tout && !st_r.irq));
    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        st_r.irq |-> st_r.count == '0);
    // R5
    toggle_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        (st_r.irq && !$past(clr)) |-> st_r.tout != $past(st_r.tout));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && !$past(clr) && !$past(rst)) |-> $stable(st_r.count));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [7:0]        mode_wdata,
    input  logic              start_set,
    input  logic              oe_we,
    input  logic              oe_wdata,
    input  logic              modulo_we,
    input  logic [DATA_W-1:0] modulo_wdata,
    input  logic              ext_evt,
    output logic [7:0]        mode_q,
    output logic [DATA_W-1:0] count_q,
    output logic              irq,
    output logic              tout_pin,
    output logic              shift_clk
);
    mode_t             mode_r;
    logic              oe_r;
    logic [DATA_W-1:0] modulo_r;
    logic              start_cmd;
    logic [TAP_COUNT-1:0] tap_tick;
    logic              ext_rise;
    logic              src_tick;
    core_state_t       st;

    assign start_cmd = (mode_we && mode_wdata[3]) || start_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r   <= '0;
            oe_r     <= 1'b0;
            modulo_r <= '0;
        end else begin
            if (mode_we)        mode_r       <= mode_t'(mode_wdata);
            else if (start_set) mode_r.start <= 1'b1;
            else                mode_r.start <= 1'b0;
            if (oe_we)     oe_r     <= oe_wdata;
            if (modulo_we) modulo_r <= modulo_wdata;
        end
    end

    evt_tmr_prescale #(.TAPS(TAP_COUNT), .STEP(TAP_STEP)) u_pre (
        .clk(clk), .rst(rst), .clr(start_cmd), .tap_tick(tap_tick)
    );

    evt_tmr_sync u_sync (
        .clk(clk), .rst(rst), .async_in(ext_evt), .rise(ext_rise)
    );

    always_comb begin
        src_tick = 1'b0;
        for (int k = 0; k < TAP_COUNT; k++) begin
            if (mode_r.src == SRC_W'(k + 1)) src_tick = tap_tick[k];
        end
        if (mode_r.src == EXT_CODE) src_tick = ext_rise;
    end

    evt_tmr_core u_core (
        .clk(clk), .rst(rst), .clr(start_cmd),
        .tick(src_tick && mode_r.run), .modulo(modulo_r), .st(st)
    );

    assign mode_q    = mode_r;
    assign count_q   = st.count;
    assign irq       = st.irq;
    assign shift_clk = st.tout;
    assign tout_pin  = st.tout & oe_r;

    // R3
    start_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode_r.start |-> $past(start_cmd));
    // R3
    start_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(start_set) && !$past(mode_we)) |-> mode_r.src == $past(mode_r.src)
            && mode_r.run == $past(mode_r.run));
    // R8
    pin_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tout_pin |-> (shift_clk && oe_r));
endmodule

// File: tb/evt_timer_tb.sv
`timescale 1ns/1ps
module evt_timer_tb;
    logic clk = 1'b0, rst = 1'b1;
    logic mode_we = 1'b0, start_set = 1'b0, oe_we = 1'b0, oe_wdata = 1'b0;
    logic modulo_we = 1'b0, ext_evt = 1'b0;
    logic [7:0] mode_wdata = '0, modulo_wdata = '0;
    logic [7:0] mode_q, count_q;
    logic irq, tout_pin, shift_clk;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    evt_timer u_dut (
        .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .start_set(start_set), .oe_we(oe_we), .oe_wdata(oe_wdata),
        .modulo_we(modulo_we), .modulo_wdata(modulo_wdata), .ext_evt(ext_evt),
        .mode_q(mode_q), .count_q(count_q), .irq(irq),
        .tout_pin(tout_pin), .shift_clk(shift_clk)
    );

    // {src 3, modulo 8, wait edges 12, expected count 8, expected tout 1}
    localparam logic [31:0] VEC [6] = '{
        {3'd1, 8'd3,   12'd20,  8'd1,  1'b1},
        {3'd2, 8'd1,   12'd100, 8'd0,  1'b1},
        {3'd1, 8'd0,   12'd13,  8'd0,  1'b1},
        {3'd3, 8'd2,   12'd200, 8'd0,  1'b1},
        {3'd4, 8'd5,   12'd600, 8'd2,  1'b0},
        {3'd1, 8'd255, 12'd40,  8'd10, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_mode(input logic [7:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wdata = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_mod(input logic [7:0] v);
        @(negedge clk); modulo_we = 1'b1; modulo_wdata = v;
        @(negedge clk); modulo_we = 1'b0;
    endtask

    task automatic wr_oe(input logic v);
        @(negedge clk); oe_we = 1'b1; oe_wdata = v;
        @(negedge clk); oe_we = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mode", mode_q, 0);
        chk("R1 count", count_q, 0);
        chk("R1 pin", tout_pin, 0);
        chk("R1 irq", irq, 0);
        chk("R1 shift", shift_clk, 0);

        wr_oe(1'b1);
        // R4 R5 R9 vector table
        for (int i = 0; i < 6; i++) begin
            wr_mod(VEC[i][28:21]);
            wr_mode({1'b0, VEC[i][31:29], 4'b1100});
            step(int'(VEC[i][20:9]));
            chk("R4/R9 count", count_q, int'(VEC[i][8:1]));
            chk("R5 tout", tout_pin, int'(VEC[i][0]));
        end

        // R7 freeze: last vector left count 10; clear run without start
        wr_mode(8'h10);
        step(20);
        chk("R7 hold count", count_q, 10);
        chk("R2 readback", mode_q, 8'h10);

        // R5 irq pulse, src 1, modulo 1: match on the 2nd pulse, edge +8
        wr_mod(8'd1);
        wr_mode(8'h1C);
        // R3 start bit high for one cycle
        chk("R3 start bit set", mode_q, 8'h1C);
        step(1);
        chk("R3 start bit clear", mode_q, 8'h14);
        step(6);
        chk("R5 irq before", irq, 0);
        chk("R5 count before", count_q, 1);
        step(1);
        chk("R5 irq pulse", irq, 1);
        chk("R5 wrap", count_q, 0);
        chk("R5 toggle", shift_clk, 1);
        step(1);
        chk("R5 irq one cycle", irq, 0);

        // R3 start_set alone
        wr_mod(8'd3);
        wr_mode(8'h1C);
        step(20);
        chk("R3 pre count", count_q, 1);
        chk("R3 pre tout", shift_clk, 1);
        @(negedge clk); start_set = 1'b1;
        @(negedge clk); start_set = 1'b0;
        chk("R3 clr count", count_q, 0);
        chk("R3 clr tout", shift_clk, 0);
        chk("R3 other bits kept", mode_q, 8'h1C);

        // R8 output gate
        wr_mod(8'd0);
        wr_mode(8'h1C);
        step(4);
        chk("R8 pin enabled", tout_pin, 1);
        wr_oe(1'b0);
        chk("R8 pin gated", tout_pin, 0);
        chk("R8 shift ungated", shift_clk, 1);

        // R6 external edges, modulo 2, seven rising edges
        wr_mod(8'd2);
        wr_mode(8'h5C);
        for (int e = 0; e < 7; e++) begin
            @(negedge clk); ext_evt = 1'b1;
            repeat (3) @(negedge clk);
            ext_evt = 1'b0;
            repeat (3) @(negedge clk);
        end
        step(8);
        chk("R6 ext count", count_q, 1);
        chk("R6 ext tout", shift_clk, 0);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 mid mode", mode_q, 0);
        chk("R1 mid count", count_q, 0);
        chk("R1 mid shift", shift_clk, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule